// File: doc/BRIEF.md
# Line-Repeating Read DMA Sequencer

This block feeds an outbound video path by reading a source picture out of memory, one line at a time, into a local FIFO. Software arms it with an enable bit and a picture geometry: a base address for each of the two fields, the number of bytes in a line, the number of lines, a signed pitch between lines, and a 2-bit repeat code. Nothing is fetched until the next begin-of-field pulse. The geometry and the selected base address are captured at that pulse, so the sequencer stays locked to the source frame for the whole field.

Each line is broken into burst requests that carry an address and a byte length. A line may be fetched up to four times in a row, always from the same start address, which lets a downstream scaler that only stretches horizontally obtain vertical upscaling by line repetition. Words that memory returns are the only words written into the FIFO. A request is only raised when the FIFO has room for a full burst on top of everything already requested. After the last pass of the last line has been requested, a one-cycle field-done pulse is given and the sequencer rearms for the next field.

Line length and burst size must be multiples of the word size (DATA_W/8 bytes), and FIFO_DEPTH must be a power of two.

Top module: `linerep_rd_dma`

## Requirements
- R1: While `chan_en` is low, from the next cycle on `req_valid` and `out_valid` are low, the FIFO is emptied, returned words are dropped and `bof` has no effect.
- R2: After `chan_en` has been high for at least one cycle, no request is raised until a `bof` pulse; the first request of the field is at `base_a` when `field_sel` is 0 and at `base_b` when it is 1, both sampled at the `bof` cycle together with the geometry inputs.
- R3: A line is split into requests in increasing address order, each at line start plus bytes already requested, with `req_len` equal to the smaller of BURST_BYTES and the bytes left in the line.
- R4: With `rep_code` = n (binary 00 to 11), every line is fetched n+1 times in succession, each pass starting again at the same line start address.
- R5: After the final pass of a line, the line start address grows by `pitch` taken as a two's-complement value, so a negative pitch walks down through memory.
- R6: When the final burst of the last line's final pass is accepted, `field_done` is high for exactly one cycle and no further request is raised until the next `bof`.
- R7: Only words presented with `rd_valid` enter the FIFO; they leave on `out_data` in the order they were returned, one per cycle in which `out_valid` and `out_ready` are both high.
- R8: `req_valid` is high only when FIFO occupancy plus words requested but not yet returned plus BURST_BYTES/(DATA_W/8) does not exceed FIFO_DEPTH.
- R9: A request that is not accepted keeps `req_valid` high and `req_addr` and `req_len` unchanged in the next cycle while `chan_en` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; low holds the channel and FIFO cleared |
| bof | input | 1 | Begin-of-field pulse |
| field_sel | input | 1 | Field select at bof: 0 uses base_a, 1 uses base_b |
| base_a | input | ADDR_W | Base address of field 0 |
| base_b | input | ADDR_W | Base address of field 1 |
| pitch | input | ADDR_W | Two's-complement byte step between line starts |
| line_bytes | input | LB_W | Bytes per source line |
| line_count | input | LN_W | Lines per field |
| rep_code | input | 2 | Line repeat code, passes per line minus one |
| req_valid | output | 1 | Burst request pending |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | ADDR_W | Byte address of the burst |
| req_len | output | LB_W | Burst length in bytes |
| rd_valid | input | 1 | Returned word valid |
| rd_data | input | DATA_W | Returned word |
| out_valid | output | 1 | FIFO holds a word |
| out_ready | input | 1 | Consumer takes the head word |
| out_data | output | DATA_W | FIFO head word |
| field_done | output | 1 | One-cycle pulse after the field's last request |

## Verification
On every cycle the assertions watch the request handshake: silence while disabled or armed, bounded burst lengths, a stalled request holding still, the occupancy-plus-inflight bound and a FIFO that is never written when full. What they cannot see is the address sequence itself: the ordering of bursts within a line, the reload of the same start on each repeat, the pitch step in both directions and the exact burst count per field are only shown by the bench's scenarios, which compare the full request log and the drained word stream against lists built from the geometry. Disabling in mid-field and rearming are likewise scenario-level behaviours.

// File: rtl/lrd_pkg.sv
package lrd_pkg;
    localparam int ADDR_W = 32;
    localparam int LB_W   = 16;
    localparam int LN_W   = 12;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_ARM = 2'd1,
        ST_RUN = 2'd2
    } walk_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] pitch;
        logic [LB_W-1:0]   line_bytes;
        logic [LN_W-1:0]   lines;
        logic [1:0]        rep;
    } frame_cfg_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LB_W-1:0]   len;
    } rd_req_t;

    function automatic logic [LB_W-1:0] chunk_len(input logic [LB_W-1:0] remaining,
                                                  input logic [LB_W-1:0] cap);
        return (remaining > cap) ? cap : remaining;
    endfunction
endpackage

// File: rtl/lrd_fifo.sv
module lrd_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        push,
    input  logic [DW-1:0]               din,
    input  logic                        pop,
    output logic [DW-1:0]               dout,
    output logic                        valid,
    output logic [$clog2(DEPTH+1)-1:0]  count
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PW'(1);
            if (pop)  rd_ptr <= rd_ptr + PW'(1);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem[wr_ptr] <= din;
    end

    assign dout  = mem[rd_ptr];
    assign valid = (cnt != '0);
    assign count = cnt;

    // R7: a returned word is never written into a full FIFO
    p_push_has_room_r7: assert property (@(posedge clk) disable iff (rst)
        (push && !clr) |-> (cnt < CW'(DEPTH)));
    // R7: reading only happens when a word is held
    p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (rst)
        pop |-> valid);
endmodule

// File: rtl/lrd_credit.sv
module lrd_credit #(
    parameter int DEPTH       = 16,
    parameter int BURST_WORDS = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        issue,
    input  logic [$clog2(DEPTH+1)-1:0]  issue_words,
    input  logic                        ret,
    input  logic [$clog2(DEPTH+1)-1:0]  fifo_count,
    output logic                        room
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int UW = CW + 2;

    logic [CW-1:0] inflight;
    logic [UW-1:0] used;

    assign used = UW'(fifo_count) + UW'(inflight);
    assign room = (used + UW'(BURST_WORDS)) <= UW'(DEPTH);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            inflight <= '0;
        end else begin
            inflight <= inflight + (issue ? issue_words : '0) - CW'(ret);
        end
    end

    // R8: stored plus outstanding words never exceed the FIFO
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        used <= UW'(DEPTH));
    // R8: a request is only granted while a whole burst still fits
    p_issue_with_room_r8: assert property (@(posedge clk) disable iff (rst)
        issue |-> room);
endmodule

// File: rtl/lrd_walker.sv
module lrd_walker
    import lrd_pkg::*;
#(
    parameter int BURST_BYTES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       chan_en,
    input  logic       bof,
    input  frame_cfg_t cfg_in,
    input  logic       room,
    input  logic       req_ready,
    output logic       req_valid,
    output rd_req_t    req,
    output logic       field_done
);
    localparam logic [LB_W-1:0] CAP = LB_W'(BURST_BYTES);

    walk_state_e       state;
    logic [ADDR_W-1:0] pitch_q;
    logic [LB_W-1:0]   lb_q;
    logic [LN_W-1:0]   lines_q;
    logic [1:0]        rep_q;
    logic [ADDR_W-1:0] line_start;
    logic [LB_W-1:0]   offset;
    logic [LN_W-1:0]   line_idx;
    logic [1:0]        rep_idx;

    logic [LB_W-1:0] cur_len;
    logic            last_chunk, last_rep, last_line, fire, cfg_empty;

    assign cur_len    = chunk_len(lb_q - offset, CAP);
    assign last_chunk = (offset + cur_len) == lb_q;
    assign last_rep   = (rep_idx == rep_q);
    assign last_line  = (line_idx == lines_q - LN_W'(1));
    assign cfg_empty  = (cfg_in.line_bytes == '0) || (cfg_in.lines == '0);

    assign req_valid  = (state == ST_RUN) && room;
    assign req.addr   = line_start + ADDR_W'(offset);
    assign req.len    = cur_len;
    assign fire       = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_OFF;
            pitch_q    <= '0;
            lb_q       <= '0;
            lines_q    <= '0;
            rep_q      <= '0;
            line_start <= '0;
            offset     <= '0;
            line_idx   <= '0;
            rep_idx    <= '0;
            field_done <= 1'b0;
        end else begin
            field_done <= 1'b0;
            if (!chan_en) begin
                state <= ST_OFF;
            end else begin
                unique case (state)
                    ST_OFF: state <= ST_ARM;
                    ST_ARM: begin
                        if (bof) begin
                            if (cfg_empty) begin
                                field_done <= 1'b1;
                            end else begin
                                pitch_q    <= cfg_in.pitch;
                                lb_q       <= cfg_in.line_bytes;
                                lines_q    <= cfg_in.lines;
                                rep_q      <= cfg_in.rep;
                                line_start <= cfg_in.base;
                                offset     <= '0;
                                line_idx   <= '0;
                                rep_idx    <= '0;
                                state      <= ST_RUN;
                            end
                        end
                    end
                    ST_RUN: begin
                        if (fire) begin
                            if (!last_chunk) begin
                                offset <= offset + cur_len;
                            end else begin
                                offset <= '0;
                                if (!last_rep) begin
                                    rep_idx <= rep_idx + 2'd1;
                                end else begin
                                    rep_idx    <= '0;
                                    line_start <= line_start + pitch_q;
                                    line_idx   <= line_idx + LN_W'(1);
                                    if (last_line) begin
                                        state      <= ST_ARM;
                                        field_done <= 1'b1;
                                    end
                                end
                            end
                        end
                    end
                    default: state <= ST_OFF;
                endcase
            end
        end
    end

    // R1: a disabled channel raises no request in the following cycle
    p_off_silent_r1: assert property (@(posedge clk) disable iff (rst)
        !chan_en |=> !req_valid);
    // R2: an armed channel only starts on a begin-of-field pulse
    p_wait_bof_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARM && !bof) |=> (state != ST_RUN));
    // R3: every burst carries between one byte and the burst cap
    p_len_bound_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req.len != '0 && req.len <= CAP));
    // R6: the done pulse is one cycle long and the request line is quiet with it
    p_done_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        field_done |-> !req_valid);
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        field_done |=> !field_done);
    // R9: a stalled request holds its address and length
    p_hold_req_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && chan_en) |=> (req_valid && $stable(req.addr) && $stable(req.len)));
endmodule

// File: rtl/linerep_rd_dma.sv
module linerep_rd_dma
    import lrd_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int BURST_BYTES = 16,
    parameter int FIFO_DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_en,
    input  logic              bof,
    input  logic              field_sel,
    input  logic [ADDR_W-1:0] base_a,
    input  logic [ADDR_W-1:0] base_b,
    input  logic [ADDR_W-1:0] pitch,
    input  logic [LB_W-1:0]   line_bytes,
    input  logic [LN_W-1:0]   line_count,
    input  logic [1:0]        rep_code,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LB_W-1:0]   req_len,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              field_done
);
    localparam int WORD_BYTES  = DATA_W / 8;
    localparam int BURST_WORDS = BURST_BYTES / WORD_BYTES;
    localparam int CW          = $clog2(FIFO_DEPTH + 1);

    frame_cfg_t    cfg;
    rd_req_t       req;
    logic          room, fire, push, pop;
    logic [CW-1:0] fifo_count, issue_words;

    always_comb begin
        cfg.base       = field_sel ? base_b : base_a;
        cfg.pitch      = pitch;
        cfg.line_bytes = line_bytes;
        cfg.lines      = line_count;
        cfg.rep        = rep_code;
    end

    lrd_walker #(.BURST_BYTES(BURST_BYTES)) u_walker (
        .clk        (clk),
        .rst        (rst),
        .chan_en    (chan_en),
        .bof        (bof),
        .cfg_in     (cfg),
        .room       (room),
        .req_ready  (req_ready),
        .req_valid  (req_valid),
        .req        (req),
        .field_done (field_done)
    );

    assign req_addr    = req.addr;
    assign req_len     = req.len;
    assign fire        = req_valid && req_ready;
    assign issue_words = CW'(req.len / LB_W'(WORD_BYTES));
    assign push        = rd_valid && chan_en;
    assign pop         = out_valid && out_ready;

    lrd_credit #(.DEPTH(FIFO_DEPTH), .BURST_WORDS(BURST_WORDS)) u_credit (
        .clk         (clk),
        .rst         (rst),
        .clr         (!chan_en),
        .issue       (fire),
        .issue_words (issue_words),
        .ret         (push),
        .fifo_count  (fifo_count),
        .room        (room)
    );

    lrd_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (!chan_en),
        .push  (push),
        .din   (rd_data),
        .pop   (pop),
        .dout  (out_data),
        .valid (out_valid),
        .count (fifo_count)
    );

    // R1: with the channel off the FIFO reads as empty one cycle later
    p_fifo_cleared_r1: assert property (@(posedge clk) disable iff (rst)
        !chan_en |=> !out_valid);
endmodule

// File: tb/linerep_rd_dma_tb.sv
module linerep_rd_dma_tb;
    import lrd_pkg::*;

    localparam int DW    = 32;
    localparam int BB    = 16;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic              chan_en = 0, bof = 0, field_sel = 0;
    logic [ADDR_W-1:0] base_a = '0, base_b = '0, pitch = '0;
    logic [LB_W-1:0]   line_bytes = '0;
    logic [LN_W-1:0]   line_count = '0;
    logic [1:0]        rep_code = '0;
    logic              req_valid, req_ready = 0;
    logic [ADDR_W-1:0] req_addr;
    logic [LB_W-1:0]   req_len;
    logic              rd_valid = 0;
    logic [DW-1:0]     rd_data = '0;
    logic              out_valid, out_ready = 0;
    logic [DW-1:0]     out_data;
    logic              field_done;

    linerep_rd_dma #(.DATA_W(DW), .BURST_BYTES(BB), .FIFO_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .chan_en(chan_en), .bof(bof), .field_sel(field_sel),
        .base_a(base_a), .base_b(base_b), .pitch(pitch), .line_bytes(line_bytes),
        .line_count(line_count), .rep_code(rep_code), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
        .rd_valid(rd_valid), .rd_data(rd_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .field_done(field_done)
    );

    int n_cmp = 0, n_bad = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [31:0] act_addr [512];
    int          act_len  [512];
    logic [31:0] exp_addr [512];
    int          exp_len  [512];
    logic [31:0] pop_word [1024];
    logic [31:0] exp_word [1024];
    int n_act = 0, n_exp = 0, n_pop = 0, n_expw = 0;
    int done_cnt = 0, req_words = 0, max_level = 0;
    int sink_mode = 0, src_mode = 0, tick = 0;
    logic [31:0] retq [$];
    bit          pend = 0;
    logic [31:0] pend_addr;
    int          pend_len;

    // memory and consumer model: drive for the coming edge, then log what that edge takes
    always @(negedge clk) begin
        tick++;
        if (pend && chan_en) begin
            check(req_valid && req_addr == pend_addr && int'(req_len) == pend_len,
                  "R9 stalled request held", req_addr, pend_addr);
        end
        req_ready = (src_mode == 0) ? 1'b1 : ((tick % 2) == 0);
        out_ready = (sink_mode == 0) ? 1'b1 : (sink_mode == 1) ? 1'b0 : ((tick % 3) == 0);
        if (retq.size() > 0 && (tick % 4) != 1) begin
            rd_valid = 1'b1;
            rd_data  = retq.pop_front();
        end else begin
            rd_valid = 1'b0;
        end
        pend = !rst && chan_en && req_valid && !req_ready;
        pend_addr = req_addr;
        pend_len  = int'(req_len);
        if (!rst && req_valid && req_ready) begin
            if (n_act < 512) begin
                act_addr[n_act] = req_addr;
                act_len[n_act]  = int'(req_len);
            end
            n_act++;
            for (int k = 0; k < int'(req_len) / 4; k++) retq.push_back(req_addr + 32'(4 * k));
            req_words += int'(req_len) / 4;
        end
        if (!rst && out_valid && out_ready) begin
            if (n_pop < 1024) pop_word[n_pop] = out_data;
            n_pop++;
        end
        if (field_done) done_cnt++;
        if (req_words - n_pop > max_level) max_level = req_words - n_pop;
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic clear_logs();
        n_act = 0; n_pop = 0; req_words = 0; max_level = 0; done_cnt = 0;
        retq.delete();
    endtask

    task automatic set_geometry(input logic [31:0] ba, input logic [31:0] bb_, input int lb,
                                input int lines, input int pt, input int rep);
        base_a = ba; base_b = bb_; line_bytes = LB_W'(lb); line_count = LN_W'(lines);
        pitch = 32'(pt); rep_code = 2'(rep);
    endtask

    task automatic build_expected(input logic [31:0] base, input int lb, input int lines,
                                  input int pt, input int rep);
        logic [31:0] ls;
        n_exp = 0; n_expw = 0; ls = base;
        for (int l = 0; l < lines; l++) begin
            for (int r = 0; r <= rep; r++) begin
                for (int off = 0; off < lb; off += ((lb - off) > BB ? BB : (lb - off))) begin
                    exp_addr[n_exp] = ls + 32'(off);
                    exp_len[n_exp]  = (lb - off) > BB ? BB : (lb - off);
                    for (int k = 0; k < exp_len[n_exp] / 4; k++) begin
                        exp_word[n_expw] = exp_addr[n_exp] + 32'(4 * k);
                        n_expw++;
                    end
                    n_exp++;
                end
            end
            ls = ls + 32'(pt);
        end
    endtask

    task automatic pulse_bof(input logic sel);
        @(posedge clk); #1;
        field_sel = sel; bof = 1'b1;
        @(posedge clk); #1;
        bof = 1'b0;
    endtask

    task automatic wait_done(input int target, input int limit);
        for (int i = 0; i < limit && done_cnt < target; i++) @(negedge clk);
    endtask

    task automatic wait_drain(input int limit);
        for (int i = 0; i < limit && n_pop < n_expw; i++) @(negedge clk);
    endtask

    task automatic compare_field(input string tag);
        check(n_act == n_exp, {tag, " R3 request count"}, n_act, n_exp);
        for (int i = 0; i < n_exp && i < n_act; i++) begin
            check(act_addr[i] == exp_addr[i], {tag, " R3,R4,R5 request address"}, act_addr[i], exp_addr[i]);
            check(act_len[i] == exp_len[i], {tag, " R3 request length"}, act_len[i], exp_len[i]);
        end
        check(n_pop == n_expw, {tag, " R7 word count"}, n_pop, n_expw);
        for (int i = 0; i < n_expw && i < n_pop; i++)
            check(pop_word[i] == exp_word[i], {tag, " R7 word order"}, pop_word[i], exp_word[i]);
        check(max_level <= DEPTH, {tag, " R8 occupancy bound"}, max_level, DEPTH);
    endtask

    task automatic t_reset();
        rst = 1'b1; chan_en = 1'b0;
        cycles(4);
        rst = 1'b0;
        @(negedge clk);
        check(req_valid == 1'b0, "R1 reset req_valid", req_valid, 0);
        check(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
        check(field_done == 1'b0, "R6 reset field_done", field_done, 0);
    endtask

    task automatic t_arm_wait();
        set_geometry(32'h0000_2000, 32'h0000_1000, 24, 3, 64, 1);
        chan_en = 1'b1;
        clear_logs();
        cycles(20);
        check(n_act == 0, "R2 no request before bof", n_act, 0);
    endtask

    task automatic t_basic();
        src_mode = 1; sink_mode = 0;
        clear_logs();
        build_expected(32'h0000_1000, 24, 3, 64, 1);
        pulse_bof(1'b1);
        wait_done(1, 2000);
        wait_drain(2000);
        check(n_act > 0 && act_addr[0] == 32'h0000_1000, "R2 first request at base_b", act_addr[0], 32'h1000);
        compare_field("basic");
        check(done_cnt == 1, "R6 one done pulse", done_cnt, 1);
        cycles(12);
        check(n_act == n_exp, "R6 idle after done", n_act, n_exp);
        check(done_cnt == 1, "R6 pulse not repeated", done_cnt, 1);
    endtask

    task automatic t_negpitch();
        src_mode = 0; sink_mode = 2;
        set_geometry(32'h0000_8000, 32'h0000_4000, 16, 2, -128, 3);
        clear_logs();
        build_expected(32'h0000_8000, 16, 2, -128, 3);
        pulse_bof(1'b0);
        wait_done(1, 2000);
        wait_drain(2000);
        check(n_act > 4 && act_addr[4] == 32'h0000_7F80, "R5 negative pitch second line", act_addr[4], 32'h7F80);
        check(n_act > 3 && act_addr[3] == 32'h0000_8000, "R4 fourth pass same start", act_addr[3], 32'h8000);
        compare_field("negpitch");
    endtask

    task automatic t_backpressure();
        src_mode = 1; sink_mode = 1;
        set_geometry(32'h0001_0000, 32'h0, 32, 4, 32, 0);
        clear_logs();
        build_expected(32'h0001_0000, 32, 4, 32, 0);
        pulse_bof(1'b0);
        cycles(100);
        check(n_act == DEPTH / (BB / 4), "R8 requests stop at full credit", n_act, DEPTH / (BB / 4));
        check(n_pop == 0, "R7 nothing leaves without out_ready", n_pop, 0);
        check(max_level <= DEPTH, "R8 level bound under stall", max_level, DEPTH);
        sink_mode = 2;
        wait_done(1, 3000);
        wait_drain(3000);
        compare_field("backpressure");
    endtask

    task automatic t_disable();
        src_mode = 0; sink_mode = 1;
        set_geometry(32'h0002_0000, 32'h0, 64, 8, 256, 3);
        clear_logs();
        pulse_bof(1'b0);
        cycles(30);
        chan_en = 1'b0;
        retq.delete();
        @(posedge clk);
        @(negedge clk);
        check(req_valid == 1'b0, "R1 request dropped on disable", req_valid, 0);
        check(out_valid == 1'b0, "R1 FIFO emptied on disable", out_valid, 0);
        clear_logs();
        pulse_bof(1'b0);
        cycles(10);
        check(n_act == 0, "R1 bof ignored while disabled", n_act, 0);
        check(out_valid == 1'b0, "R1 FIFO stays empty while disabled", out_valid, 0);
        chan_en = 1'b1;
        sink_mode = 0;
        set_geometry(32'h0003_0000, 32'h0004_0000, 20, 2, 48, 2);
        clear_logs();
        cycles(10);
        check(n_act == 0, "R2 rearmed channel waits for bof", n_act, 0);
        build_expected(32'h0004_0000, 20, 2, 48, 2);
        pulse_bof(1'b1);
        wait_done(1, 2000);
        wait_drain(2000);
        compare_field("rearm");
    endtask

    initial begin
        #1500000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_arm_wait();
        t_basic();
        t_negpitch();
        t_backpressure();
        t_disable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule